// File: doc/BRIEF.md
# Machine/Supervisor Status Register Unit

This unit keeps one status control register for a hart and shows it to software in two ways. The machine view reaches every implemented field. The supervisor view is not a second register. It is a filtered window onto the same storage: a read through it returns only the fields that supervisor code may see, and a write through it changes only the fields that supervisor code may change. All other bits are kept as they were.

Every field outside the implemented set reads as zero and cannot be written. A summary dirty flag sits in the top bit of the selected width. It is never stored: it is computed from the floating-point and extension state fields each time the register is read. When a write changes a field that controls address translation, the unit raises a single-cycle flush request towards the translation cache. The view select is one input bit. Privilege checking and full CSR address decoding are handled outside this block.

Top module: `status_csr_unit`

## Requirements
- R1: After reset every stored bit is zero, a read through either view returns zero, and `tlb_flush` is low.
- R2: A machine-view write (`csr_sel_sup`=0, `csr_we`=1) stores `csr_wdata` into these bits only: 1 (SIE), 3 (MIE), 5 (SPIE), 7 (MPIE), 8 (SPP), 12:11 (MPP), 14:13 (FS), 17 (MPRV), 18 (SUM), 19 (MXR), 20 (TVM), 21 (TW) and 22 (TSR). The result shows on the read port one cycle after the write edge.
- R3: Bits 16:15 (XS) take the write data only when `ext_present` is high. When `ext_present` is low, XS keeps its old value on a write through either view.
- R4: A supervisor-view write (`csr_sel_sup`=1) changes only bits 1, 5, 8, 14:13, 18, 19 and (under R3) 16:15. Every other stored bit keeps its value.
- R5: The cycle after a write through either view changes any of bits 12:11, 17, 18 or 19, `tlb_flush` is high for exactly that one cycle. It stays low after a write that leaves all four unchanged, and when no write takes place.
- R6: A supervisor-view read returns the stored bits 1, 5, 8, 13–16, 18 and 19, plus the summary flag. All other bits read as zero.
- R7: The summary flag (bit XLEN-1: 63 when XLEN=64, 31 when XLEN=32) reads as 1 in both views exactly when FS equals 2'b11 or XS equals 2'b11.
- R8: In the machine view, any bit not named in R2, R3 or R7 always reads as zero, whatever was written to it.
- R9: `csr_rdata` is combinational: it follows `csr_sel_sup` and the current stored value with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_sel_sup | input | 1 | View select: 0 selects the machine view, 1 the supervisor view |
| csr_we | input | 1 | Write enable for the selected view |
| csr_wdata | input | XLEN | Write data |
| ext_present | input | 1 | High when an extension with its own state is present; makes XS writable |
| csr_rdata | output | XLEN | Read data for the selected view |
| tlb_flush | output | 1 | Single-cycle translation-cache flush request |

## Verification
The assertions assume that `csr_we` is held low while reset is asserted, so that the first sampled history after reset release holds no write. They also assume that `csr_sel_sup` and `ext_present` stay stable through each write edge, because the stored result depends on their values at that edge. The bench changes all inputs only at the falling edge and keeps the write enable low throughout reset. It sweeps every single-bit write pattern, plus a pseudo-random set of patterns, through both views with the extension input both low and high, and it changes the view select only between edges to read back both windows.

// File: rtl/status_pkg.sv
package status_pkg;

   // Field bit positions. These are architectural: other units decode them.
   localparam int B_SIE  = 1;
   localparam int B_MIE  = 3;
   localparam int B_SPIE = 5;
   localparam int B_MPIE = 7;
   localparam int B_SPP  = 8;
   localparam int B_MPP  = 11;   // two bits, 12:11
   localparam int B_FS   = 13;   // two bits, 14:13
   localparam int B_XS   = 15;   // two bits, 16:15
   localparam int B_MPRV = 17;
   localparam int B_SUM  = 18;
   localparam int B_MXR  = 19;
   localparam int B_TVM  = 20;
   localparam int B_TW   = 21;
   localparam int B_TSR  = 22;

   localparam int FIELD_TOP = 22;   // highest implemented storage bit

   typedef logic [63:0] mask64_t;

   function automatic mask64_t bit1(input int pos);
      mask64_t m;
      m = '0;
      m[pos] = 1'b1;
      return m;
   endfunction

   function automatic mask64_t bit2(input int pos);
      return bit1(pos) | bit1(pos + 1);
   endfunction

   function automatic mask64_t xs_field();
      return bit2(B_XS);
   endfunction

   // Bits a machine-view write may change; XS joins when the extension exists.
   function automatic mask64_t mach_wr_mask(input logic ext);
      mask64_t m;
      m = bit1(B_SIE) | bit1(B_MIE) | bit1(B_SPIE) | bit1(B_MPIE) |
          bit1(B_SPP) | bit2(B_MPP) | bit2(B_FS)   | bit1(B_MPRV) |
          bit1(B_SUM) | bit1(B_MXR) | bit1(B_TVM)  | bit1(B_TW)   |
          bit1(B_TSR);
      if (ext) m = m | xs_field();
      return m;
   endfunction

   // Bits a supervisor-view write may change, before the machine gate.
   function automatic mask64_t sup_wr_mask();
      return bit1(B_SIE) | bit1(B_SPIE) | bit1(B_SPP) | bit2(B_FS) |
             xs_field()  | bit1(B_SUM)  | bit1(B_MXR);
   endfunction

   // Stored bits visible through each view.
   function automatic mask64_t mach_rd_mask();
      return mach_wr_mask(1'b1);
   endfunction

   function automatic mask64_t sup_rd_mask();
      return sup_wr_mask();
   endfunction

   // Fields whose change invalidates cached translations.
   function automatic mask64_t xlate_mask();
      return bit2(B_MPP) | bit1(B_MPRV) | bit1(B_SUM) | bit1(B_MXR);
   endfunction

   // Fields only the machine view may touch.
   function automatic mask64_t mach_only_mask();
      return mach_wr_mask(1'b1) & ~sup_wr_mask();
   endfunction

endpackage

// File: rtl/stat_mask_gen.sv
module stat_mask_gen
   import status_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            sel_sup,
   input  logic            ext_present,
   output logic [XLEN-1:0] wr_mask,
   output logic [XLEN-1:0] rd_mask
);

   mask64_t mw_ext;
   mask64_t mw_noext;
   mask64_t mw;
   mask64_t wr_full;
   mask64_t rd_full;

   always_comb begin
      mw_ext   = mach_wr_mask(1'b1);
      mw_noext = mach_wr_mask(1'b0);
      mw       = ext_present ? mw_ext : mw_noext;
      // Supervisor writes pass through the machine gate as well.
      wr_full  = sel_sup ? (sup_wr_mask() & mw) : mw;
      rd_full  = sel_sup ? sup_rd_mask() : mach_rd_mask();
   end

   assign wr_mask = wr_full[XLEN-1:0];
   assign rd_mask = rd_full[XLEN-1:0];

endmodule

// File: rtl/stat_dirty_sum.sv
module stat_dirty_sum
   import status_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] state_q,
   output logic [XLEN-1:0] sd_vec
);

   localparam int SD_POS = XLEN - 1;

   logic fs_dirty;
   logic xs_dirty;

   assign fs_dirty = &state_q[B_FS+1:B_FS];
   assign xs_dirty = &state_q[B_XS+1:B_XS];

   generate
      if (XLEN == 64) begin : g_sd64
         always_comb begin
            sd_vec = '0;
            sd_vec[63] = fs_dirty | xs_dirty;
         end
      end else begin : g_sd32
         always_comb begin
            sd_vec = '0;
            sd_vec[SD_POS] = fs_dirty | xs_dirty;
         end
      end
   endgenerate

endmodule

// File: rtl/stat_flush_det.sv
module stat_flush_det
   import status_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_fire,
   input  logic [XLEN-1:0] old_val,
   input  logic [XLEN-1:0] new_val,
   output logic            flush
);

   localparam mask64_t XM64 = xlate_mask();
   localparam logic [XLEN-1:0] XM = XM64[XLEN-1:0];

   logic changed;

   assign changed = |((old_val ^ new_val) & XM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flush <= 1'b0;
      else        flush <= wr_fire & changed;
   end

endmodule

// File: rtl/status_csr_unit.sv
module status_csr_unit
   import status_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            csr_sel_sup,
   input  logic            csr_we,
   input  logic [XLEN-1:0] csr_wdata,
   input  logic            ext_present,
   output logic [XLEN-1:0] csr_rdata,
   output logic            tlb_flush
);

   generate
      if (!(XLEN == 32 || XLEN == 64)) begin : g_bad_xlen
         $error("status_csr_unit: XLEN must be 32 or 64");
      end
      if (XLEN - 1 <= FIELD_TOP) begin : g_bad_room
         $error("status_csr_unit: XLEN too small for field layout");
      end
   endgenerate

   logic [XLEN-1:0] store_q;
   logic [XLEN-1:0] store_d;
   logic [XLEN-1:0] wr_mask;
   logic [XLEN-1:0] rd_mask;
   logic [XLEN-1:0] sd_vec;

   stat_mask_gen #(.XLEN(XLEN)) u_mask (
      .sel_sup     (csr_sel_sup),
      .ext_present (ext_present),
      .wr_mask     (wr_mask),
      .rd_mask     (rd_mask)
   );

   assign store_d = (store_q & ~wr_mask) | (csr_wdata & wr_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      store_q <= '0;
      else if (csr_we) store_q <= store_d;
   end

   stat_dirty_sum #(.XLEN(XLEN)) u_sd (
      .state_q (store_q),
      .sd_vec  (sd_vec)
   );

   stat_flush_det #(.XLEN(XLEN)) u_flush (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (csr_we),
      .old_val (store_q),
      .new_val (store_d),
      .flush   (tlb_flush)
   );

   assign csr_rdata = (store_q & rd_mask) | sd_vec;

endmodule

// File: rtl/stat_unit_chk.sv
module stat_unit_chk
   import status_pkg::*;
#(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            csr_sel_sup,
   input logic            csr_we,
   input logic            ext_present,
   input logic [XLEN-1:0] csr_rdata,
   input logic            tlb_flush,
   input logic [XLEN-1:0] store_q
);

   localparam mask64_t MO64 = mach_only_mask();
   localparam mask64_t XM64 = xlate_mask();
   localparam mask64_t RD64 = mach_rd_mask();
   localparam logic [XLEN-1:0] MONLY = MO64[XLEN-1:0];
   localparam logic [XLEN-1:0] XMASK = XM64[XLEN-1:0];
   localparam logic [XLEN-1:0] LEGAL = RD64[XLEN-1:0] | (XLEN'(1) << (XLEN - 1));

   // R5: a flush request only follows a write
   p_flush_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_flush |-> $past(csr_we));

   // R5: a write that moved a translation field raises the flush
   p_flush_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(csr_we) && ((($past(store_q) ^ store_q) & XMASK) != '0)) |-> tlb_flush);

   // R2: with no write, the stored value holds
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(csr_we) |-> (store_q == $past(store_q)));

   // R4: supervisor writes leave machine-only fields alone
   p_sup_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(csr_we && csr_sel_sup) |-> ((store_q & MONLY) == ($past(store_q) & MONLY)));

   // R3: XS is frozen when the extension is absent
   p_xs_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(csr_we && !ext_present) |-> (store_q[16:15] == $past(store_q[16:15])));

   // R8: no bit outside the legal set ever reads as one
   p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rdata & ~LEGAL) == '0);

   // R7: summary flag tracks the dirty fields
   p_sd_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rdata[XLEN-1] == ((store_q[14:13] == 2'b11) || (store_q[16:15] == 2'b11)));

endmodule

bind status_csr_unit stat_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .csr_sel_sup (csr_sel_sup),
   .csr_we      (csr_we),
   .ext_present (ext_present),
   .csr_rdata   (csr_rdata),
   .tlb_flush   (tlb_flush),
   .store_q     (store_q)
);

// File: tb/sim_status_csr_unit.sv
`timescale 1ns/1ps
module sim_status_csr_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_sel_sup = 1'b0;
   logic        csr_we = 1'b0;
   logic [63:0] csr_wdata = '0;
   logic        ext_present = 1'b0;
   logic [63:0] csr_rdata;
   logic        tlb_flush;

   int n_chk = 0;
   int n_fail = 0;
   logic [63:0] model = '0;
   logic [63:0] rng = 64'h9E3779B97F4A7C15;

   always #10 clk = ~clk;   // 50 MHz

   status_csr_unit #(.XLEN(64)) u0 (
      .clk, .rst_n, .csr_sel_sup, .csr_we, .csr_wdata,
      .ext_present, .csr_rdata, .tlb_flush
   );

   // Masks built from the bit lists in the requirements.
   function automatic logic [63:0] mw(input bit ext);
      logic [63:0] m;
      m = (64'd1 << 1) | (64'd1 << 3) | (64'd1 << 5) | (64'd1 << 7) | (64'd1 << 8) |
          (64'd3 << 11) | (64'd3 << 13) | (64'd1 << 17) | (64'd1 << 18) |
          (64'd1 << 19) | (64'd1 << 20) | (64'd1 << 21) | (64'd1 << 22);
      if (ext) m = m | (64'd3 << 15);
      return m;
   endfunction

   function automatic logic [63:0] sw(input bit ext);
      logic [63:0] m;
      m = (64'd1 << 1) | (64'd1 << 5) | (64'd1 << 8) | (64'd3 << 13) |
          (64'd1 << 18) | (64'd1 << 19);
      if (ext) m = m | (64'd3 << 15);
      return m;
   endfunction

   function automatic logic [63:0] sdbit(input logic [63:0] v);
      return ((v[14:13] == 2'b11) || (v[16:15] == 2'b11)) ? (64'd1 << 63) : 64'd0;
   endfunction

   function automatic logic [63:0] exp_mach(input logic [63:0] v);
      return v | sdbit(v);
   endfunction

   function automatic logic [63:0] exp_sup(input logic [63:0] v);
      logic [63:0] rm;
      rm = (64'd1 << 1) | (64'd1 << 5) | (64'd1 << 8) | (64'd15 << 13) |
           (64'd1 << 18) | (64'd1 << 19);
      return (v & rm) | sdbit(v);
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Read both views between edges (R9: combinational read).
   task automatic read_both(input string tag);
      csr_sel_sup = 1'b0;
      #1;
      chk({tag, " R2 R8 machine view"}, csr_rdata, exp_mach(model));
      csr_sel_sup = 1'b1;
      #1;
      chk({tag, " R6 supervisor view"}, csr_rdata, exp_sup(model));
      csr_sel_sup = 1'b0;
      #1;
      chk({tag, " R9 view switch"}, csr_rdata, exp_mach(model));
   endtask

   task automatic do_wr(input bit sup, input logic [63:0] d, input bit ext);
      logic [63:0] m;
      logic [63:0] nv;
      logic        fl;
      csr_sel_sup = sup;
      csr_we      = 1'b1;
      csr_wdata   = d;
      ext_present = ext;
      m  = sup ? (sw(ext) & mw(ext)) : mw(ext);
      nv = (model & ~m) | (d & m);
      fl = (((model ^ nv) & ((64'd3 << 11) | (64'd7 << 17))) != 64'd0);
      @(posedge clk);
      @(negedge clk);
      csr_we = 1'b0;
      model = nv;
      chk("R5 flush after write", {63'd0, tlb_flush}, {63'd0, fl});
      read_both(sup ? "R4 R3 sup write" : "R2 R3 mach write");
      @(negedge clk);
      chk("R5 flush single cycle", {63'd0, tlb_flush}, 64'd0);
   endtask

   function automatic logic [63:0] next_rng(input logic [63:0] x);
      logic [63:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 7);
      y = y ^ (y << 17);
      return y;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rdata in reset", csr_rdata, 64'd0);
      chk("R1 flush in reset", {63'd0, tlb_flush}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      read_both("R1 after reset");
      chk("R1 flush after reset", {63'd0, tlb_flush}, 64'd0);

      // Single-bit sweep, both views, extension low and high.
      for (int e = 0; e < 2; e++) begin
         for (int s = 0; s < 2; s++) begin
            for (int b = 0; b < 64; b++) begin
               if (s == 1) do_wr(1'b0, '1, 1'b1);
               do_wr(s[0], 64'd1 << b, e[0]);
            end
         end
      end

      // R3: XS ignored when the extension is absent
      do_wr(1'b0, 64'd0, 1'b1);
      do_wr(1'b0, 64'd3 << 15, 1'b0);
      chk("R3 XS held with ext low", csr_rdata, 64'd0);
      do_wr(1'b1, 64'd3 << 15, 1'b0);
      chk("R3 XS held via sup with ext low", csr_rdata, 64'd0);

      // R7: summary flag from FS and from XS
      do_wr(1'b0, 64'd3 << 13, 1'b0);
      chk("R7 SD from FS", csr_rdata, (64'd3 << 13) | (64'd1 << 63));
      do_wr(1'b0, 64'd3 << 15, 1'b1);
      chk("R7 SD from XS", csr_rdata, (64'd3 << 15) | (64'd1 << 63));
      do_wr(1'b0, 64'd1 << 13, 1'b1);
      chk("R7 SD clear", csr_rdata, 64'd1 << 13);

      // R5: rewriting the same translation value gives no flush
      do_wr(1'b0, 64'd1 << 18, 1'b1);
      do_wr(1'b0, (64'd1 << 18) | (64'd1 << 3), 1'b1);
      do_wr(1'b1, 64'd1 << 19, 1'b1);

      // Pseudo-random patterns across views and extension setting.
      for (int i = 0; i < 400; i++) begin
         rng = next_rng(rng);
         do_wr(rng[0], next_rng(rng), rng[1]);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule